// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the program counter of a processor that fetches 32-bit instruction words at byte addresses aligned to four, and it works out the address of the next fetch in the same cycle. The sequential successor is the current address plus four. A conditional relative branch adds a signed word displacement to that successor. A region jump replaces the low part of the successor with a field taken from the instruction. Decode logic outside the block supplies two flags, one for a branch and one for a jump. A comparator outside the block reports whether the two branch operands are equal.

The counter register is loaded on every rising clock edge. There is no separate write enable. A synchronous active-high reset loads a start address given by a parameter. The successor value and the chosen next address are also driven to ports. A fetch stage can then read the next address one cycle early, and a link or return path can use the successor.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` is loaded with `START_ADDR` (0x0040_0000 in the bench). It stays there until the first edge with `rst` low.
- R2: `pc_plus4` always equals `pc + 4` modulo 2^32, so 0xFFFF_FFFC is followed by 0x0000_0000.
- R3: When `jmp_en` is low and a branch is not taken, `pc_next` equals `pc_plus4`. This value is loaded into `pc` at the next edge.
- R4: When `br_en` and `ops_equal` are both high and `jmp_en` is low, `pc_next` equals `pc_plus4` plus instruction bits [15:0], read as a two's-complement word count and multiplied by four. This holds up to the largest forward count, 0x7FFF.
- R5: When `br_en` is high and `ops_equal` is low, the branch falls through to `pc_plus4`.
- R6: A negative displacement moves the address backwards with modulo-2^32 wrap. This includes the most negative count, 0x8000, and steps that pass below address zero.
- R7: When `jmp_en` is high, `pc_next` bits [31:28] are taken from `pc_plus4` bits [31:28]. Bits [27:2] are instruction bits [25:0], and bits [1:0] are zero. A successor that has just entered a new 256 MB region gives the new region.
- R8: When `jmp_en` and a taken branch occur together, the jump target wins.
- R9: The two low bits of `pc` are zero at every edge after reset.
- R10: When `br_en` and `jmp_en` are both low, `ops_equal` and the instruction bits have no effect on the next address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Instruction word being executed |
| br_en | input | 1 | Decoded conditional branch flag |
| jmp_en | input | 1 | Decoded region jump flag |
| ops_equal | input | 1 | Equality of the two branch operands |
| pc | output | 32 | Current program counter |
| pc_plus4 | output | 32 | Sequential successor of `pc` |
| pc_next | output | 32 | Address loaded into `pc` at the next edge |

## Verification
The embedded properties assume that `br_en`, `jmp_en`, `ops_equal` and `instr` are known and stable across each rising edge once reset has been released. They also assume that reset is held for at least one edge at start-up. The bench keeps to these assumptions by driving every input on the falling edge only. It starts with two reset edges, and its mid-run reset is held for a whole cycle. The stimulus includes flag combinations that decode would never produce, such as both flags high, so the priority rule is exercised at the block's edge. The stimulus also includes instruction bits that are set without any flag, to show that they are ignored.

// File: rtl/npc_pkg.sv
`timescale 1ns/1ps
package npc_pkg;

   typedef enum logic [1:0] {
      NPC_SEL_SEQ    = 2'd0,
      NPC_SEL_BRANCH = 2'd1,
      NPC_SEL_JUMP   = 2'd2
   } npc_sel_e;

   // Priority: region jump first, then a taken branch, else the successor.
   function automatic npc_sel_e npc_pick(input logic br, input logic jmp, input logic eq);
      npc_sel_e s;
      if (jmp)
         s = NPC_SEL_JUMP;
      else if (br && eq)
         s = NPC_SEL_BRANCH;
      else
         s = NPC_SEL_SEQ;
      return s;
   endfunction

endpackage

// File: rtl/npc_seq_inc.sv
`timescale 1ns/1ps
module npc_seq_inc #(
   parameter int ADDR_W   = 32,
   parameter bit WORD_INC = 1'b1
) (
   input  logic [ADDR_W-1:0] pc_in,
   output logic [ADDR_W-1:0] pc_succ
);
   localparam int IDX_W = ADDR_W - 2;

   generate
      if (WORD_INC) begin : g_word
         // Low bits of an aligned address are constant zero: count words only.
         logic [IDX_W-1:0] word_idx;
         logic             unused_low;
         assign unused_low = ^pc_in[1:0];
         assign word_idx   = pc_in[ADDR_W-1:2] + IDX_W'(1);
         assign pc_succ    = {word_idx, 2'b00};
      end else begin : g_full
         assign pc_succ = pc_in + ADDR_W'(4);
      end
   endgenerate

endmodule

// File: rtl/npc_targets.sv
`timescale 1ns/1ps
module npc_targets #(
   parameter int ADDR_W   = 32,
   parameter int INSTR_W  = 32,
   parameter int OFF_W    = 16,
   parameter int JFIELD_W = 26
) (
   input  logic [ADDR_W-1:0]  pc_succ,
   input  logic [INSTR_W-1:0] instr,
   output logic [ADDR_W-1:0]  br_target,
   output logic [ADDR_W-1:0]  jmp_target
);
   localparam int REGION_W = ADDR_W - JFIELD_W - 2;
   localparam int EXT_W    = ADDR_W - OFF_W - 2;

   logic [OFF_W-1:0]    disp;
   logic [ADDR_W-1:0]   disp_bytes;
   logic [JFIELD_W-1:0] jfield;
   logic                unused_bits;

   assign disp   = instr[OFF_W-1:0];
   assign jfield = instr[JFIELD_W-1:0];

   // Sign-extended word displacement, scaled to bytes.
   assign disp_bytes = {{EXT_W{disp[OFF_W-1]}}, disp, 2'b00};
   assign br_target  = pc_succ + disp_bytes;

   generate
      if (REGION_W > 0) begin : g_region
         assign jmp_target  = {pc_succ[ADDR_W-1 -: REGION_W], jfield, 2'b00};
      end else begin : g_flat
         assign jmp_target  = {jfield, 2'b00};
      end
      if (INSTR_W > JFIELD_W) begin : g_op_unused
         assign unused_bits = ^instr[INSTR_W-1:JFIELD_W];
      end else begin : g_op_none
         assign unused_bits = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/npc_select.sv
`timescale 1ns/1ps
module npc_select
   import npc_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              br_en,
   input  logic              jmp_en,
   input  logic              ops_equal,
   input  logic [ADDR_W-1:0] seq_addr,
   input  logic [ADDR_W-1:0] br_addr,
   input  logic [ADDR_W-1:0] jmp_addr,
   output npc_sel_e          sel,
   output logic [ADDR_W-1:0] next_addr
);

   assign sel = npc_pick(br_en, jmp_en, ops_equal);

   always_comb begin
      unique case (sel)
         NPC_SEL_JUMP:   next_addr = jmp_addr;
         NPC_SEL_BRANCH: next_addr = br_addr;
         default:        next_addr = seq_addr;
      endcase
   end

endmodule

// File: rtl/npc_unit.sv
`timescale 1ns/1ps
module npc_unit
   import npc_pkg::*;
#(
   parameter int              ADDR_W     = 32,
   parameter int              INSTR_W    = 32,
   parameter int              OFF_W      = 16,
   parameter int              JFIELD_W   = 26,
   parameter logic [ADDR_W-1:0] START_ADDR = '0,
   parameter bit              WORD_INC   = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [INSTR_W-1:0] instr,
   input  logic               br_en,
   input  logic               jmp_en,
   input  logic               ops_equal,
   output logic [ADDR_W-1:0]  pc,
   output logic [ADDR_W-1:0]  pc_plus4,
   output logic [ADDR_W-1:0]  pc_next
);
   localparam int REGION_W = ADDR_W - JFIELD_W - 2;

   generate
      if (ADDR_W < OFF_W + 3) begin : g_bad_off
         $error("npc_unit: ADDR_W too narrow for OFF_W");
      end
      if (REGION_W < 0) begin : g_bad_jfield
         $error("npc_unit: JFIELD_W too wide for ADDR_W");
      end
      if (INSTR_W < JFIELD_W || INSTR_W < OFF_W) begin : g_bad_instr
         $error("npc_unit: instruction narrower than its fields");
      end
      if (START_ADDR[1:0] != 2'b00) begin : g_bad_start
         $error("npc_unit: START_ADDR must be word aligned");
      end
   endgenerate

   logic [ADDR_W-1:0] br_target;
   logic [ADDR_W-1:0] jmp_target;
   npc_sel_e          sel;

   npc_seq_inc #(.ADDR_W(ADDR_W), .WORD_INC(WORD_INC)) u_inc (
      .pc_in   (pc),
      .pc_succ (pc_plus4)
   );

   npc_targets #(
      .ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .OFF_W(OFF_W), .JFIELD_W(JFIELD_W)
   ) u_tgt (
      .pc_succ    (pc_plus4),
      .instr      (instr),
      .br_target  (br_target),
      .jmp_target (jmp_target)
   );

   npc_select #(.ADDR_W(ADDR_W)) u_sel (
      .br_en     (br_en),
      .jmp_en    (jmp_en),
      .ops_equal (ops_equal),
      .seq_addr  (pc_plus4),
      .br_addr   (br_target),
      .jmp_addr  (jmp_target),
      .sel       (sel),
      .next_addr (pc_next)
   );

   always_ff @(posedge clk) begin
      if (rst) pc <= START_ADDR;
      else     pc <= pc_next;
   end

   // ---------------- embedded checks ----------------
   logic [ADDR_W-1:0] chk_disp;
   assign chk_disp = ADDR_W'($signed(instr[OFF_W-1:0])) <<< 2;

   a_r1_reset_value: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> pc == START_ADDR);

   a_r2_successor: assert property (@(posedge clk) disable iff (rst)
      pc_plus4 - pc == ADDR_W'(4));

   a_r3_sequential: assert property (@(posedge clk) disable iff (rst)
      (!jmp_en && !(br_en && ops_equal)) |=> pc == $past(pc) + ADDR_W'(4));

   a_r4_branch_taken: assert property (@(posedge clk) disable iff (rst)
      (br_en && ops_equal && !jmp_en) |=> pc == $past(pc) + ADDR_W'(4) + $past(chk_disp));

   a_r9_aligned: assert property (@(posedge clk) disable iff (rst)
      pc[1:0] == 2'b00);

   generate
      if (REGION_W > 0) begin : g_jchk
         a_r8_jump_wins: assert property (@(posedge clk) disable iff (rst)
            jmp_en |=> (pc[ADDR_W-REGION_W-1:2] == $past(instr[JFIELD_W-1:0]))
                    && (pc[ADDR_W-1 -: REGION_W] == $past(pc_plus4[ADDR_W-1 -: REGION_W])));
      end
   endgenerate

endmodule

// File: tb/sim_npc_unit.sv
`timescale 1ns/1ps
module sim_npc_unit;
   localparam real         HALF_NS = 10.0;
   localparam logic [31:0] START   = 32'h0040_0000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] instr = '0;
   logic        br_en = 1'b0, jmp_en = 1'b0, ops_equal = 1'b0;
   logic [31:0] pc, pc_plus4, pc_next;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [31:0] model_pc = '0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #(HALF_NS) clk = ~clk;

   npc_unit #(.START_ADDR(START)) u0 (
      .clk(clk), .rst(rst), .instr(instr), .br_en(br_en), .jmp_en(jmp_en),
      .ops_equal(ops_equal), .pc(pc), .pc_plus4(pc_plus4), .pc_next(pc_next)
   );

   function automatic logic [31:0] ref_next(input logic [31:0] p, input logic [31:0] ins,
                                            input logic b, input logic j, input logic e);
      logic [31:0] s;
      s = p + 32'd4;
      if (j)          return {s[31:28], ins[25:0], 2'b00};
      else if (b && e) return s + {{14{ins[15]}}, ins[15:0], 2'b00};
      else            return s;
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // Driver: applies one cycle of stimulus and queues the expected PC.
   task automatic step(input logic r, input logic [31:0] ins, input logic b,
                       input logic j, input logic e, input string req);
      logic [31:0] exp;
      @(negedge clk);
      rst = r; instr = ins; br_en = b; jmp_en = j; ops_equal = e;
      exp = r ? START : ref_next(model_pc, ins, b, j, e);
      #1;
      if (!r) begin
         check(pc_plus4 == model_pc + 32'd4, "R2", pc_plus4, model_pc + 32'd4);
         check(pc_next == exp, req, pc_next, exp);
      end
      exp_q.push_back(exp);
      tag_q.push_back(req);
      model_pc = exp;
   endtask

   // Monitor: pops one expectation per edge and compares the loaded PC.
   initial begin
      forever begin
         @(posedge clk);
         if (exp_q.size() > 0) begin
            logic [31:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            #4;
            check(pc == e, t, pc, e);
            check(pc[1:0] == 2'b00, "R9", {30'd0, pc[1:0]}, 32'd0);
         end
      end
   end

   initial begin
      step(1'b1, 32'h0, 1'b0, 1'b0, 1'b0, "R1");
      step(1'b1, 32'h0, 1'b0, 1'b0, 1'b0, "R1");
      step(1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, "R10");      // 0x00400004
      step(1'b0, 32'h1234_5678, 1'b0, 1'b0, 1'b0, "R3");       // 0x00400008
      step(1'b0, 32'h1000_0010, 1'b1, 1'b0, 1'b1, "R4");       // 0x0040004C
      step(1'b0, 32'h1000_0100, 1'b1, 1'b0, 1'b0, "R5");       // 0x00400050
      step(1'b0, 32'h1000_FFF0, 1'b1, 1'b0, 1'b1, "R6");       // 0x00400014
      step(1'b0, 32'h1000_7FFF, 1'b1, 1'b0, 1'b1, "R4");       // 0x00420014
      step(1'b0, 32'h1000_8000, 1'b1, 1'b0, 1'b1, "R6");       // 0x00400018
      step(1'b0, 32'h0BFF_FFFF, 1'b0, 1'b1, 1'b0, "R7");       // 0x0FFFFFFC
      step(1'b0, 32'h0800_0010, 1'b1, 1'b1, 1'b1, "R8");       // 0x10000040
      step(1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b0, "R3");       // 0x10000044
      step(1'b1, 32'h0800_0003, 1'b0, 1'b1, 1'b1, "R1");       // back to START
      step(1'b0, 32'h0800_0000, 1'b0, 1'b1, 1'b0, "R7");       // 0x00000000
      step(1'b0, 32'h1000_FFFE, 1'b1, 1'b0, 1'b1, "R6");       // 0xFFFFFFFC
      step(1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b1, "R2");       // 0x00000000
      step(1'b0, 32'h0000_0004, 1'b1, 1'b0, 1'b0, "R5");       // 0x00000004
      @(negedge clk);
      br_en = 1'b0; jmp_en = 1'b0;
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(HALF_NS * 2.0 * 2000.0);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule